// File: doc/BRIEF.md
# Flash Code-Fetch Read Controller

This block sits between a processor fetch port and an embedded flash array that is read one 32-bit word at a time. It serves byte, halfword and word reads and keeps two 32-bit line buffers. A read whose word is already buffered is answered in the same cycle. A read that misses starts a flash access, which lasts one cycle plus a programmable number of wait states.

For instruction fetches the block reads ahead. When a 16-bit code fetch reads the upper halfword of a buffered word, the flash access for the following word starts in that same cycle. A straight run of 16-bit instructions therefore stalls only on its first fetch. Data reads use the same buffers but never cause a read-ahead.

The processor raises `req` with an address, a size and a code/data flag. It holds them until `rdy` is high in a cycle, and `rdata` is valid in that cycle. The flash port is a read strobe and a word index. The flash answers on `fl_rdata` while the index is held.

Top module: `flash_fetch_ctrl`

## Requirements
- R1: A request whose word is held in a valid buffer is answered with `rdy` high in the cycle the request is presented, with no stall cycle.
- R2: A request whose word is neither buffered nor being fetched stalls for exactly 1+W cycles, where W is the wait-state count. `fl_rd` is high for the 1+W access cycles, with `fl_addr` equal to the word index `addr[FLASH_AW+1:2]`.
- R3: A buffered 16-bit code fetch (`size`=1, `is_code`=1) at byte offset 2 starts the access for word index +1 in its own cycle. This shows as `fl_rd` high with `fl_addr` = index+1, unless that word is already buffered or an access is in progress.
- R4: Data reads (`is_code`=0) never start a read-ahead. A later code fetch of the next word then pays the full miss latency.
- R5: `wait_cfg` gives 0 to 3 wait states. It is sampled only in the first cycle of an access, so a change made during an access affects only later accesses.
- R6: With `wait_cfg`=0, a sequential run of 16-bit code fetches stalls only on its first fetch.
- R7: The `size` encoding is 0 for byte, 1 for halfword and 2 for word. Byte and halfword results are picked from the word by `addr[1:0]` in little-endian order and zero-extended to 32 bits. Word reads ignore `addr[1:0]`.
- R8: Address bits at and above bit FLASH_AW+2 are ignored, so the flash contents repeat across the address window. The read-ahead index wraps from the last word to word 0.
- R9: A miss invalidates both buffers. It abandons any access in progress for another word, then stalls for 1+W cycles.
- R10: A request for the word whose access is already in progress waits for that access to finish and starts no second access.
- R11: During and right after reset, `rdy` and `fl_rd` are low and both buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_cfg | input | WS_W | Wait states per flash access |
| req | input | 1 | Read request, held until `rdy` |
| addr | input | ADDR_W | Byte address of the read |
| size | input | 2 | 0 byte, 1 halfword, 2 word |
| is_code | input | 1 | 1 for an instruction fetch, 0 for a data read |
| rdy | output | 1 | Read data valid in this cycle |
| rdata | output | 32 | Zero-extended read result |
| fl_rd | output | 1 | Flash read in progress |
| fl_addr | output | FLASH_AW | Flash word index |
| fl_rdata | input | 32 | Flash word for `fl_addr` |

## Verification
The bench builds the controller with FLASH_AW=6, which gives a 64-word flash in a 256-byte window. This makes alias addresses and the wrap of the read-ahead from word 63 to word 0 reachable with short address values. ADDR_W stays at 32, so addresses with the top bit set test the ignored upper bits. WS_W stays at 2 and `wait_cfg` is swept over 0, 2 and 3. At 3 wait states the window is wide enough to request the word whose read-ahead is in progress, to branch away from it, and to change `wait_cfg` in the middle of an access.

// File: rtl/fetch_pkg.sv
// Shared types for the flash fetch controller.
package fetch_pkg;

    // Read width code presented on the processor side.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } fetch_size_e;

endpackage

// File: rtl/fetch_access_timer.sv
// Flash access sequencer.
// Starts one access on 'start', lasts 1+ws cycles, and raises 'cap' in the
// last cycle so the word on the flash bus can be stored.
// Assumes: a new start abandons any access in progress; ws is sampled only on start.
module fetch_access_timer #(
    parameter int WORD_AW = 10,
    parameter int WS_W    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WORD_AW-1:0] start_word,
    input  logic [WS_W-1:0]    ws,
    output logic               busy,
    output logic [WORD_AW-1:0] cur_word,
    output logic               cap,
    output logic [WORD_AW-1:0] cap_word,
    output logic               fl_rd
);

    logic               busy_q;
    logic [WS_W-1:0]    left_q;
    logic [WORD_AW-1:0] word_q;

    // Track the remaining wait cycles of the access in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            word_q <= '0;
        end else if (start) begin
            word_q <= start_word;
            busy_q <= (ws != '0);
            left_q <= (ws == '0) ? '0 : ws - WS_W'(1);
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                left_q <= left_q - WS_W'(1);
            end
        end
    end

    // Drive the flash port and flag the final cycle of the access.
    always_comb begin
        cap_word = start ? start_word : word_q;
        fl_rd    = start || busy_q;
        cap      = (start && (ws == '0)) || (busy_q && (left_q == '0) && !start);
    end

    assign busy     = busy_q;
    assign cur_word = word_q;

endmodule

// File: rtl/fetch_line_store.sv
// Two 32-bit line buffers, one per word-index parity.
// Consecutive words never evict each other, so a read-ahead keeps the current word.
// Assumes: a capture overrides a flush for the slot it writes.
module fetch_line_store #(
    parameter int WORD_AW = 10,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               cap,
    input  logic [WORD_AW-1:0] cap_word,
    input  logic [DATA_W-1:0]  cap_data,
    input  logic [WORD_AW-1:0] look_word,
    input  logic [WORD_AW-1:0] next_word,
    output logic               hit,
    output logic [DATA_W-1:0]  hit_data,
    output logic               next_held
);

    localparam int NUM_SLOTS = 2;

    logic [NUM_SLOTS-1:0] slot_valid;
    logic [WORD_AW-1:0]   slot_tag  [NUM_SLOTS];
    logic [DATA_W-1:0]    slot_data [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic               valid_q;
        logic [WORD_AW-1:0] tag_q;
        logic [DATA_W-1:0]  data_q;

        // Fill this slot on a capture of its parity, clear it on a flush.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= 1'b0;
                tag_q   <= '0;
                data_q  <= '0;
            end else if (cap && (cap_word[0] == 1'(g))) begin
                valid_q <= 1'b1;
                tag_q   <= cap_word;
                data_q  <= cap_data;
            end else if (flush) begin
                valid_q <= 1'b0;
            end
        end

        assign slot_valid[g] = valid_q;
        assign slot_tag[g]   = tag_q;
        assign slot_data[g]  = data_q;
    end

    // Look up the requested word and its successor.
    always_comb begin
        hit       = slot_valid[look_word[0]] && (slot_tag[look_word[0]] == look_word);
        hit_data  = slot_data[look_word[0]];
        next_held = slot_valid[next_word[0]] && (slot_tag[next_word[0]] == next_word);
    end

endmodule

// File: rtl/fetch_lane_pick.sv
// Selects the byte or halfword lane of a word, little-endian, and zero-extends it.
// Assumes: word reads ignore the low address bits.
module fetch_lane_pick
    import fetch_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_in,
    input  logic [1:0]        byte_off,
    input  fetch_size_e       size_in,
    output logic [DATA_W-1:0] data_out
);

    // Shift the selected lane down and mask it to its width.
    always_comb begin
        case (size_in)
            SZ_BYTE: data_out = DATA_W'(word_in[8*byte_off +: 8]);
            SZ_HALF: data_out = DATA_W'(word_in[16*byte_off[1] +: 16]);
            default: data_out = word_in;
        endcase
    end

endmodule

// File: rtl/flash_fetch_ctrl.sv
// Flash read controller with a two-word buffer and code read-ahead.
// Buffer hits answer in the same cycle. Misses start a 1+wait_cfg cycle access.
// A 16-bit code fetch of the upper half of a buffered word starts the next word's access.
// Assumes: the requester holds req and its fields until rdy; the flash returns
// the word for fl_addr combinationally while it is held.
module flash_fetch_ctrl
    import fetch_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int FLASH_AW = 10,
    parameter int WS_W     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WS_W-1:0]     wait_cfg,
    input  logic                req,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          size,
    input  logic                is_code,
    output logic                rdy,
    output logic [31:0]         rdata,
    output logic                fl_rd,
    output logic [FLASH_AW-1:0] fl_addr,
    input  logic [31:0]         fl_rdata
);

    localparam int DATA_W  = 32;
    localparam int BYTE_AW = FLASH_AW + 2;

    fetch_size_e         size_e;
    logic [FLASH_AW-1:0] req_word;
    logic [FLASH_AW-1:0] next_word;
    logic [FLASH_AW-1:0] start_word;
    logic [FLASH_AW-1:0] cur_word;
    logic [FLASH_AW-1:0] cap_word;
    logic                hit;
    logic                next_held;
    logic                busy;
    logic                cap;
    logic                wait_same;
    logic                miss_start;
    logic                ahead_start;
    logic                start;
    logic [DATA_W-1:0]   hit_data;
    logic                unused_addr_hi;

    // Decode the request: alias the window onto the flash and find the successor.
    always_comb begin
        size_e         = fetch_size_e'(size);
        req_word       = addr[BYTE_AW-1:2];
        next_word      = req_word + FLASH_AW'(1);
        unused_addr_hi = ^addr[ADDR_W-1:BYTE_AW];
    end

    // Choose between a demand access, a read-ahead, or waiting on the access in progress.
    always_comb begin
        wait_same   = busy && (cur_word == req_word);
        miss_start  = req && !hit && !wait_same;
        ahead_start = req && hit && is_code && (size_e == SZ_HALF) && addr[1]
                      && !busy && !next_held;
        start       = miss_start || ahead_start;
        start_word  = miss_start ? req_word : next_word;
    end

    fetch_access_timer #(
        .WORD_AW (FLASH_AW),
        .WS_W    (WS_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (start_word),
        .ws         (wait_cfg),
        .busy       (busy),
        .cur_word   (cur_word),
        .cap        (cap),
        .cap_word   (cap_word),
        .fl_rd      (fl_rd)
    );

    fetch_line_store #(
        .WORD_AW (FLASH_AW),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (miss_start),
        .cap       (cap),
        .cap_word  (cap_word),
        .cap_data  (fl_rdata),
        .look_word (req_word),
        .next_word (next_word),
        .hit       (hit),
        .hit_data  (hit_data),
        .next_held (next_held)
    );

    fetch_lane_pick #(
        .DATA_W (DATA_W)
    ) u_pick (
        .word_in  (hit_data),
        .byte_off (addr[1:0]),
        .size_in  (size_e),
        .data_out (rdata)
    );

    // Answer on a buffer hit and expose the access word on the flash port.
    always_comb begin
        rdy     = req && hit;
        fl_addr = cap_word;
    end

endmodule

// File: rtl/flash_fetch_ctrl_chk.sv
// Property checker for the flash fetch controller, attached by bind.
// Assumes: the requester holds its request until rdy.
module flash_fetch_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [1:0]  size,
    input logic        is_code,
    input logic        rdy,
    input logic [31:0] rdata,
    input logic        fl_rd
);

    logic [2:0] stall_run;

    // Count consecutive stalled request cycles, saturating at seven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_run <= '0;
        end else if (req && !rdy) begin
            stall_run <= (stall_run == 3'd7) ? stall_run : stall_run + 3'd1;
        end else begin
            stall_run <= '0;
        end
    end

    AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> req); // R1

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= 3'd4); // R2

    AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && size == 2'd0) |-> (rdata[31:8] == 24'd0)); // R7

    AST_HALF_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && size == 2'd1) |-> (rdata[31:16] == 16'd0)); // R7

    AST_DATA_NO_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !is_code && !$past(fl_rd)) |-> !fl_rd); // R4

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !$past(fl_rd)) |-> !fl_rd); // R3

endmodule

bind flash_fetch_ctrl flash_fetch_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .size    (size),
    .is_code (is_code),
    .rdy     (rdy),
    .rdata   (rdata),
    .fl_rd   (fl_rd)
);

// File: tb/flash_fetch_ctrl_bench.sv
module flash_fetch_ctrl_bench;

    localparam int ADDR_W   = 32;
    localparam int FLASH_AW = 6;
    localparam int WS_W     = 2;
    localparam int NW       = 1 << FLASH_AW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [WS_W-1:0]     wait_cfg = '0;
    logic                req = 1'b0;
    logic [ADDR_W-1:0]   addr = '0;
    logic [1:0]          size = '0;
    logic                is_code = 1'b0;
    logic                rdy;
    logic [31:0]         rdata;
    logic                fl_rd;
    logic [FLASH_AW-1:0] fl_addr;
    logic [31:0]         fl_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    // Flash content: distinct bytes per word.
    function automatic logic [31:0] flash_word(input int w);
        logic [7:0] x;
        x = 8'(w);
        return {x ^ 8'hA5, x, ~x, x + 8'h3C};
    endfunction

    // Expected lane of a word for an address and size.
    function automatic logic [31:0] lane(input logic [31:0] w, input logic [31:0] a, input logic [1:0] sz);
        if (sz == 2'd0) return (w >> (8 * a[1:0])) & 32'hFF;
        if (sz == 2'd1) return (w >> (16 * a[1])) & 32'hFFFF;
        return w;
    endfunction

    assign fl_rdata = flash_word(int'(fl_addr));

    flash_fetch_ctrl #(
        .ADDR_W   (ADDR_W),
        .FLASH_AW (FLASH_AW),
        .WS_W     (WS_W)
    ) u_flash_fetch_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_cfg (wait_cfg),
        .req      (req),
        .addr     (addr),
        .size     (size),
        .is_code  (is_code),
        .rdy      (rdy),
        .rdata    (rdata),
        .fl_rd    (fl_rd),
        .fl_addr  (fl_addr),
        .fl_rdata (fl_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: two parity buffers and one pending access.
    bit          mv [2];
    int          mt [2];
    logic [31:0] md [2];
    bit          mbusy;
    int          mword;
    int          mleft;

    task automatic m_store(input int s);
        mv[s % 2] = 1'b1;
        mt[s % 2] = s;
        md[s % 2] = flash_word(s);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            mv[0] = 1'b0; mv[1] = 1'b0;
            mbusy = 1'b0; mword = 0; mleft = 0;
        end else begin
            int w, nw, sw, ws;
            bit hit, same, miss, ahead, st, nheld;
            logic [31:0] ed;
            ws    = int'(wait_cfg);
            w     = int'(addr[FLASH_AW+1:2]);
            nw    = (w + 1) % NW;
            hit   = req && mv[w % 2] && (mt[w % 2] == w);
            same  = mbusy && (mword == w);
            miss  = req && !hit && !same;
            nheld = mv[nw % 2] && (mt[nw % 2] == nw);
            ahead = hit && is_code && (size == 2'd1) && addr[1] && !mbusy && !nheld;
            st    = miss || ahead;
            sw    = miss ? w : nw;
            ed    = lane(md[w % 2], addr, size);
            check(rdy === hit, "R1 rdy per cycle", 32'(rdy), 32'(hit));
            if (hit) check(rdata === ed, "R7 rdata per cycle", rdata, ed);
            check(fl_rd === (st || mbusy), "R3 fl_rd per cycle", 32'(fl_rd), 32'(st || mbusy));
            if (st || mbusy) check(int'(fl_addr) == (st ? sw : mword), "R2 fl_addr per cycle",
                                   32'(fl_addr), 32'(st ? sw : mword));
            if (miss) begin mv[0] = 1'b0; mv[1] = 1'b0; end
            if (st) begin
                if (ws == 0) begin m_store(sw); mbusy = 1'b0; end
                else begin mbusy = 1'b1; mword = sw; mleft = ws - 1; end
            end else if (mbusy) begin
                if (mleft == 0) begin m_store(mword); mbusy = 1'b0; end
                else mleft--;
            end
        end
    end

    task automatic fetch(input logic [31:0] a, input logic [1:0] sz, input bit code,
                         output int stalls, output logic [31:0] data,
                         output logic rd_seen, output logic [FLASH_AW-1:0] addr_seen);
        @(posedge clk); #1;
        req = 1'b1; addr = a; size = sz; is_code = code;
        stalls = 0;
        while (1) begin
            @(negedge clk); #1;
            if (rdy) break;
            stalls++;
        end
        data = rdata; rd_seen = fl_rd; addr_seen = fl_addr;
    endtask

    task automatic idle(input logic [WS_W-1:0] ws);
        @(posedge clk); #1;
        req = 1'b0; wait_cfg = ws;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R2 watchdog expired actual %0d expected %0d", cycles, 20000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int st;
        logic [31:0] d;
        logic rd;
        logic [FLASH_AW-1:0] ad;

        repeat (3) @(posedge clk);
        #1;
        check(rdy === 1'b0, "R11 rdy in reset", 32'(rdy), 0);
        check(fl_rd === 1'b0, "R11 fl_rd in reset", 32'(fl_rd), 0);
        rst_n = 1'b1;

        // Sequential code at zero wait states.
        fetch(32'h0, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 1, "R11 empty after reset, R2 miss stall", st, 1);
        check(d == lane(flash_word(0), 0, 1), "R7 half at 0", d, lane(flash_word(0), 0, 1));
        fetch(32'h2, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 0, "R1 hit no stall", st, 0);
        check(rd && ad == 1, "R3 read-ahead of word 1", {rd, 8'(ad)}, {1'b1, 8'd1});
        for (int k = 2; k < 16; k++) begin
            fetch(32'(2 * k), 2'd1, 1'b1, st, d, rd, ad);
            check(st == 0, "R6 sequential zero stall", st, 0);
        end

        // Data reads do not read ahead.
        fetch(32'h40, 2'd1, 1'b0, st, d, rd, ad);
        check(st == 1, "R2 data miss", st, 1);
        fetch(32'h42, 2'd1, 1'b0, st, d, rd, ad);
        check(st == 0 && !rd, "R4 no access on data upper half", {st[7:0], 7'd0, rd}, 0);
        fetch(32'h44, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 1, "R4 next word not fetched ahead", st, 1);

        // Two wait states, branch flushes.
        idle(2'd2);
        fetch(32'h20, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 3, "R2 miss with two waits", st, 3);
        fetch(32'h44, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 3, "R9 buffers flushed by miss", st, 3);

        // Three wait states, wait on the access in progress.
        idle(2'd3);
        fetch(32'h10, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 4, "R2 miss with three waits", st, 4);
        fetch(32'h12, 2'd1, 1'b1, st, d, rd, ad);
        check(rd && ad == 5, "R3 read-ahead of word 5", {rd, 8'(ad)}, {1'b1, 8'd5});
        fetch(32'h14, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 3, "R10 wait for in-flight word", st, 3);
        check(d == lane(flash_word(5), 32'h14, 1), "R10 data of in-flight word", d, lane(flash_word(5), 32'h14, 1));

        // Branch away from an access in progress.
        fetch(32'h16, 2'd1, 1'b1, st, d, rd, ad);
        check(rd && ad == 6, "R3 read-ahead of word 6", {rd, 8'(ad)}, {1'b1, 8'd6});
        fetch(32'h80, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 4, "R9 abandon access and branch", st, 4);
        fetch(32'h18, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 4, "R9 abandoned word not kept", st, 4);

        // Wait-state change in the middle of an access.
        @(posedge clk); #1;
        req = 1'b1; addr = 32'h70; size = 2'd1; is_code = 1'b1;
        st = 0;
        @(negedge clk); #1;
        if (!rdy) st++;
        @(posedge clk); #1;
        wait_cfg = 2'd0;
        while (1) begin
            @(negedge clk); #1;
            if (rdy) break;
            st++;
        end
        check(st == 4, "R5 wait count held for the access", st, 4);
        fetch(32'hA0, 2'd1, 1'b0, st, d, rd, ad);
        check(st == 1, "R5 new count on next access", st, 1);

        // Sizes and lanes.
        fetch(32'hA1, 2'd0, 1'b0, st, d, rd, ad);
        check(d == lane(flash_word(40), 32'hA1, 0), "R7 byte 1", d, lane(flash_word(40), 32'hA1, 0));
        fetch(32'hA3, 2'd0, 1'b0, st, d, rd, ad);
        check(d == lane(flash_word(40), 32'hA3, 0), "R7 byte 3", d, lane(flash_word(40), 32'hA3, 0));
        fetch(32'hA2, 2'd1, 1'b0, st, d, rd, ad);
        check(d == lane(flash_word(40), 32'hA2, 1), "R7 upper half", d, lane(flash_word(40), 32'hA2, 1));
        fetch(32'hA3, 2'd2, 1'b0, st, d, rd, ad);
        check(d == flash_word(40), "R7 word ignores low bits", d, flash_word(40));

        // Aliasing and wrap of the read-ahead.
        fetch(32'h1A0, 2'd2, 1'b0, st, d, rd, ad);
        check(st == 0 && d == flash_word(40), "R8 alias hit", d, flash_word(40));
        fetch(32'h8000_00A2, 2'd1, 1'b0, st, d, rd, ad);
        check(st == 0, "R8 top bit ignored", st, 0);
        fetch(32'hFC, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 1, "R2 miss on last word", st, 1);
        fetch(32'hFE, 2'd1, 1'b1, st, d, rd, ad);
        check(rd && ad == 0, "R8 read-ahead wraps to 0", {rd, 8'(ad)}, {1'b1, 8'd0});
        fetch(32'h100, 2'd1, 1'b1, st, d, rd, ad);
        check(st == 0 && d == lane(flash_word(0), 0, 1), "R8 wrapped word served", d, lane(flash_word(0), 0, 1));

        idle(2'd0);
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule